// File: doc/BRIEF.md
# Dual-Clock Serial Word Bypass Channel

This block is one channel of a pair of serial voice-data ports: a companded-PCM port and a compressed-code port. Each port has its own bit clock, an input-slot sync and an output-slot sync. When bypass is enabled, an 8-bit word shifted in on one port is replayed bit for bit on the other port's serial output, in the slot that the other port's sync selects. The two ports can run at unrelated bit rates. Whole words cross between the two clock domains through a holding register and a toggle handshake.

Each serial output has a drive enable. The enable is high only while the eight bits of a slot are on the line. When the enable is low the pad is high impedance. The channel has an active-low power-down that stops capture and output. A law-select bit passes through as a status output and does not touch the data. The output side keeps sticky flags. One records a slot that had to repeat an old word. The other records a word that was overwritten before it could be sent.

Top module: `slot_bypass_channel`

## Requirements
- R1: With bypass=1 and pwr_n=1, a word captured on the PCM input is sent unchanged on the code output, MSB first, 8 bits.
- R2: With bypass=1 and pwr_n=1, a word captured on the code input is sent unchanged on the PCM output, MSB first, 8 bits.
- R3: A slot starts when its sync is sampled high on a rising bit-clock edge. An output slot drives its MSB from that edge and changes bits on each later rising edge. An input slot samples its MSB on the next falling edge and the following bits on the next seven falling edges.
- R4: A drive enable is 1 for exactly 8 bit periods, from the slot's starting rising edge to the eighth rising edge after it. It is 0 at all other times.
- R5: The two ports work with unrelated bit-clock periods.
- R6: While bypass=0, no word is captured and both drive enables stay 0. The last captured word is kept.
- R7: While pwr_n=0, no word is captured and both drive enables stay 0. The held words are kept.
- R8: law_status equals law_sel one PCM bit clock later. law_sel has no effect on the bypassed data.
- R9: An output slot with no new word since the last slot sends the previous word again and sets that side's sticky dup flag.
- R10: When two words arrive before one output slot, the newer word is sent and that side's sticky drop flag is set.
- R11: Reset sets both drive enables and all four flags to 0, and sets the held words to 8'hFF. The first slot after reset therefore sends 8'hFF and sets dup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by both bit clocks |
| bypass | input | 1 | 1 enables the word bypass in both directions |
| pwr_n | input | 1 | 0 powers the channel down |
| law_sel | input | 1 | Companding law select, 1 = A-law, 0 = mu-law |
| law_status | output | 1 | Registered copy of law_sel |
| pcm_bclk | input | 1 | PCM port bit clock |
| pcm_rx_sync | input | 1 | PCM input-slot sync |
| pcm_tx_sync | input | 1 | PCM output-slot sync |
| pcm_sdi | input | 1 | PCM serial data in |
| pcm_sdo | output | 1 | PCM serial data out |
| pcm_sdo_oe | output | 1 | PCM output drive enable; 0 = high impedance |
| pcm_tx_dup | output | 1 | Sticky: PCM slot repeated a word |
| pcm_tx_drop | output | 1 | Sticky: a word bound for PCM was overwritten |
| cod_bclk | input | 1 | Code port bit clock |
| cod_rx_sync | input | 1 | Code input-slot sync |
| cod_tx_sync | input | 1 | Code output-slot sync |
| cod_sdi | input | 1 | Code serial data in |
| cod_sdo | output | 1 | Code serial data out |
| cod_sdo_oe | output | 1 | Code output drive enable; 0 = high impedance |
| cod_tx_dup | output | 1 | Sticky: code slot repeated a word |
| cod_tx_drop | output | 1 | Sticky: a word bound for code was overwritten |

## Verification
The bench sends all 256 byte values in each direction, with the two clocks at different periods. A design with a reversed bit order, an off-by-one bit count or a wrong crossing direction would return corrupted words. At every bit of every slot it checks the drive enable, including the bit period before the slot and the one after it. This catches an output that turns on early or leaves its last bit driven. It checks that slots with bypass off or with the channel powered down stay silent and capture nothing: a wrong gate would output data or replace the held word. It also forces a repeated word and an overwritten word, and checks the first word after reset. Missing or swapped flags, or a wrong reset word, show up there.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam int unsigned WORD_BITS  = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic {
        SIDE_PCM = 1'b0,
        SIDE_COD = 1'b1
    } side_e;

    typedef struct packed {
        logic dup;
        logic drop;
    } xfer_flags_t;

    function automatic logic toggle_edge(input logic now_v, input logic was_v);
        return now_v ^ was_v;
    endfunction

endpackage

// File: rtl/sbp_rx_deser.sv
module sbp_rx_deser #(
    parameter int unsigned W = sbp_pkg::WORD_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sync,
    input  logic         sdi,
    output logic [W-1:0] hold_word,
    output logic         hold_tgl
);
    localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          go;
    logic          busy;
    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;

    // slot start is seen on the rising edge
    always_ff @(posedge clk) begin
        if (rst) go <= 1'b0;
        else     go <= sync & en;
    end

    // data bits are taken on falling edges
    always_ff @(negedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            sh        <= '0;
            hold_word <= '1;
            hold_tgl  <= 1'b0;
        end else if (!en) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            sh <= {sh[W-2:0], sdi};
            if (cnt == LAST) begin
                hold_word <= {sh[W-2:0], sdi};
                hold_tgl  <= ~hold_tgl;
                busy      <= 1'b0;
                cnt       <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (go) begin
            sh   <= {sh[W-2:0], sdi};
            cnt  <= CW'(1);
            busy <= 1'b1;
        end
    end
endmodule

// File: rtl/sbp_word_sync.sv
module sbp_word_sync #(
    parameter int unsigned W      = sbp_pkg::WORD_BITS,
    parameter int unsigned STAGES = sbp_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_word,
    input  logic         src_tgl,
    input  logic         take,
    output logic [W-1:0] slot_word,
    output sbp_pkg::xfer_flags_t flags
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              fresh;
    logic              arrive;

    assign arrive = sbp_pkg::toggle_edge(chain[STAGES-1], prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain     <= '0;
            prev      <= 1'b0;
            slot_word <= '1;
            fresh     <= 1'b0;
            flags     <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], src_tgl};
            prev  <= chain[STAGES-1];
            if (arrive) begin
                slot_word <= src_word;
                fresh     <= 1'b1;
                if (fresh && !take) flags.drop <= 1'b1;
            end
            if (take) begin
                if (!fresh)  flags.dup <= 1'b1;
                if (!arrive) fresh     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sbp_tx_ser.sv
module sbp_tx_ser #(
    parameter int unsigned W = sbp_pkg::WORD_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sync,
    input  logic [W-1:0] word,
    output logic         take,
    output logic         sdo,
    output logic         oe
);
    localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;

    logic [W-1:0]  sh;
    logic [CW-1:0] left;

    assign take = sync & en & ~oe;
    assign sdo  = sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            oe   <= 1'b0;
            left <= '0;
            sh   <= '0;
        end else if (!en) begin
            oe   <= 1'b0;
            left <= '0;
        end else if (take) begin
            sh   <= word;
            oe   <= 1'b1;
            left <= CW'(W - 1);
        end else if (oe) begin
            if (left == '0) begin
                oe <= 1'b0;
            end else begin
                sh   <= {sh[W-2:0], 1'b0};
                left <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/slot_bypass_channel.sv
module slot_bypass_channel #(
    parameter int unsigned W           = sbp_pkg::WORD_BITS,
    parameter int unsigned SYNC_STAGES = sbp_pkg::SYNC_DEPTH
) (
    input  logic rst,
    input  logic bypass,
    input  logic pwr_n,
    input  logic law_sel,
    output logic law_status,
    input  logic pcm_bclk,
    input  logic pcm_rx_sync,
    input  logic pcm_tx_sync,
    input  logic pcm_sdi,
    output logic pcm_sdo,
    output logic pcm_sdo_oe,
    output logic pcm_tx_dup,
    output logic pcm_tx_drop,
    input  logic cod_bclk,
    input  logic cod_rx_sync,
    input  logic cod_tx_sync,
    input  logic cod_sdi,
    output logic cod_sdo,
    output logic cod_sdo_oe,
    output logic cod_tx_dup,
    output logic cod_tx_drop
);
    import sbp_pkg::*;

    localparam int unsigned NSIDE = 2;

    logic              en;
    logic [NSIDE-1:0]  bclk, rx_sync, tx_sync, sdi, sdo, oe, take, tgl;
    logic [W-1:0]      hold   [NSIDE];
    logic [W-1:0]      slot_w [NSIDE];
    xfer_flags_t       flg    [NSIDE];

    assign en      = bypass & pwr_n;
    assign bclk    = {cod_bclk,    pcm_bclk};
    assign rx_sync = {cod_rx_sync, pcm_rx_sync};
    assign tx_sync = {cod_tx_sync, pcm_tx_sync};
    assign sdi     = {cod_sdi,     pcm_sdi};

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam int OTHER = NSIDE - 1 - s;

        sbp_rx_deser #(.W(W)) u_rx (
            .clk       (bclk[s]),
            .rst       (rst),
            .en        (en),
            .sync      (rx_sync[s]),
            .sdi       (sdi[s]),
            .hold_word (hold[s]),
            .hold_tgl  (tgl[s])
        );

        sbp_word_sync #(.W(W), .STAGES(SYNC_STAGES)) u_xfer (
            .clk       (bclk[s]),
            .rst       (rst),
            .src_word  (hold[OTHER]),
            .src_tgl   (tgl[OTHER]),
            .take      (take[s]),
            .slot_word (slot_w[s]),
            .flags     (flg[s])
        );

        sbp_tx_ser #(.W(W)) u_tx (
            .clk  (bclk[s]),
            .rst  (rst),
            .en   (en),
            .sync (tx_sync[s]),
            .word (slot_w[s]),
            .take (take[s]),
            .sdo  (sdo[s]),
            .oe   (oe[s])
        );
    end

    always_ff @(posedge pcm_bclk) begin
        if (rst) law_status <= 1'b0;
        else     law_status <= law_sel;
    end

    assign pcm_sdo     = sdo[SIDE_PCM];
    assign pcm_sdo_oe  = oe[SIDE_PCM];
    assign pcm_tx_dup  = flg[SIDE_PCM].dup;
    assign pcm_tx_drop = flg[SIDE_PCM].drop;
    assign cod_sdo     = sdo[SIDE_COD];
    assign cod_sdo_oe  = oe[SIDE_COD];
    assign cod_tx_dup  = flg[SIDE_COD].dup;
    assign cod_tx_drop = flg[SIDE_COD].drop;
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
    parameter int unsigned W = sbp_pkg::WORD_BITS
) (
    input logic rst,
    input logic bypass,
    input logic pwr_n,
    input logic pcm_bclk,
    input logic pcm_sdo_oe,
    input logic pcm_tx_dup,
    input logic pcm_tx_drop,
    input logic cod_bclk,
    input logic cod_sdo_oe,
    input logic cod_tx_dup,
    input logic cod_tx_drop
);
    logic [5:0] pcm_run, cod_run;

    always_ff @(posedge pcm_bclk) begin
        if (rst) pcm_run <= '0;
        else     pcm_run <= pcm_sdo_oe ? pcm_run + 1'b1 : '0;
    end
    always_ff @(posedge cod_bclk) begin
        if (rst) cod_run <= '0;
        else     cod_run <= cod_sdo_oe ? cod_run + 1'b1 : '0;
    end

    assert_pcm_slot_len_R4: assert property (@(posedge pcm_bclk) disable iff (rst)
        32'(pcm_run) <= W);
    assert_cod_slot_len_R4: assert property (@(posedge cod_bclk) disable iff (rst)
        32'(cod_run) <= W);

    assert_pcm_quiet_bypass_R6: assert property (@(posedge pcm_bclk) disable iff (rst)
        !bypass |=> !pcm_sdo_oe);
    assert_cod_quiet_bypass_R6: assert property (@(posedge cod_bclk) disable iff (rst)
        !bypass |=> !cod_sdo_oe);

    assert_pcm_quiet_pdn_R7: assert property (@(posedge pcm_bclk) disable iff (rst)
        !pwr_n |=> !pcm_sdo_oe);
    assert_cod_quiet_pdn_R7: assert property (@(posedge cod_bclk) disable iff (rst)
        !pwr_n |=> !cod_sdo_oe);

    assert_pcm_dup_sticky_R9: assert property (@(posedge pcm_bclk) disable iff (rst)
        pcm_tx_dup |=> pcm_tx_dup);
    assert_cod_dup_sticky_R9: assert property (@(posedge cod_bclk) disable iff (rst)
        cod_tx_dup |=> cod_tx_dup);

    assert_pcm_drop_sticky_R10: assert property (@(posedge pcm_bclk) disable iff (rst)
        pcm_tx_drop |=> pcm_tx_drop);
    assert_cod_drop_sticky_R10: assert property (@(posedge cod_bclk) disable iff (rst)
        cod_tx_drop |=> cod_tx_drop);

    assert_pcm_reset_R11: assert property (@(posedge pcm_bclk)
        rst |=> (!pcm_sdo_oe && !pcm_tx_dup && !pcm_tx_drop));
    assert_cod_reset_R11: assert property (@(posedge cod_bclk)
        rst |=> (!cod_sdo_oe && !cod_tx_dup && !cod_tx_drop));
endmodule

bind slot_bypass_channel sbp_checker #(.W(W)) u_chk (.*);

// File: tb/slot_bypass_channel_tb.sv
`timescale 1ns/1ps
module slot_bypass_channel_tb;
    logic rst = 1'b1, bypass = 1'b1, pwr_n = 1'b1, law_sel = 1'b0;
    logic law_status;
    logic pcm_bclk = 1'b0, pcm_rx_sync = 1'b0, pcm_tx_sync = 1'b0, pcm_sdi = 1'b0;
    logic pcm_sdo, pcm_sdo_oe, pcm_tx_dup, pcm_tx_drop;
    logic cod_bclk = 1'b0, cod_rx_sync = 1'b0, cod_tx_sync = 1'b0, cod_sdi = 1'b0;
    logic cod_sdo, cod_sdo_oe, cod_tx_dup, cod_tx_drop;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 pcm_bclk = ~pcm_bclk;  // 200 MHz
    always #3.5 cod_bclk = ~cod_bclk;  // unrelated rate (R5)

    slot_bypass_channel u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wpos(input bit s);
        if (s) @(posedge cod_bclk); else @(posedge pcm_bclk);
    endtask
    task automatic wneg(input bit s);
        if (s) @(negedge cod_bclk); else @(negedge pcm_bclk);
    endtask
    function automatic logic oe_of(input bit s);
        return s ? cod_sdo_oe : pcm_sdo_oe;
    endfunction
    function automatic logic sdo_of(input bit s);
        return s ? cod_sdo : pcm_sdo;
    endfunction

    // shift one word into side s (R3 input timing)
    task automatic send(input bit s, input logic [7:0] w);
        wneg(s); #1;
        if (s) cod_rx_sync = 1'b1; else pcm_rx_sync = 1'b1;
        wpos(s); #1;
        if (s) begin cod_rx_sync = 1'b0; cod_sdi = w[7]; end
        else   begin pcm_rx_sync = 1'b0; pcm_sdi = w[7]; end
        for (int i = 6; i >= 0; i--) begin
            wpos(s); #1;
            if (s) cod_sdi = w[i]; else pcm_sdi = w[i];
        end
        wneg(s);
        repeat (10) wpos(!s);
    endtask

    // run one output slot on side s and check enable window (R3, R4) and data
    task automatic recv(input bit s, input bit on, input logic [7:0] exp, input string req);
        logic [7:0] got;
        int bad = 0;
        wneg(s);
        if (oe_of(s) !== 1'b0) bad++;
        #1;
        if (s) cod_tx_sync = 1'b1; else pcm_tx_sync = 1'b1;
        wpos(s); #1;
        if (s) cod_tx_sync = 1'b0; else pcm_tx_sync = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wneg(s);
            if (oe_of(s) !== on) bad++;
            got[i] = sdo_of(s);
        end
        wneg(s);
        if (oe_of(s) !== 1'b0) bad++;
        chk(bad == 0, on ? "R4 enable window" : "R6/R7 silent slot", bad, 0);
        if (on) chk(got === exp, req, got, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (6) @(posedge cod_bclk);
        #1 rst = 1'b0;
        repeat (3) @(posedge cod_bclk);
    endtask

    initial begin
        #900000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11 reset state
        chk(pcm_sdo_oe == 0 && cod_sdo_oe == 0, "R11 enables", {pcm_sdo_oe, cod_sdo_oe}, 0);
        chk({pcm_tx_dup, pcm_tx_drop, cod_tx_dup, cod_tx_drop} == 0, "R11 flags",
            {pcm_tx_dup, pcm_tx_drop, cod_tx_dup, cod_tx_drop}, 0);

        // R1 R2 R5 full byte sweep both ways at unrelated rates
        for (int v = 0; v < 256; v++) begin
            send(0, 8'(v));
            recv(1, 1'b1, 8'(v), "R1 pcm->cod");
            send(1, 8'(v) ^ 8'hA5);
            recv(0, 1'b1, 8'(v) ^ 8'hA5, "R2 cod->pcm");
        end
        chk({pcm_tx_dup, pcm_tx_drop, cod_tx_dup, cod_tx_drop} == 0, "R9/R10 no false flag",
            {pcm_tx_dup, pcm_tx_drop, cod_tx_dup, cod_tx_drop}, 0);

        // R8 law select
        law_sel = 1'b1;
        repeat (2) @(posedge pcm_bclk); #1;
        chk(law_status == 1'b1, "R8 law_status", law_status, 1);
        send(0, 8'h3C);
        recv(1, 1'b1, 8'h3C, "R8 data unchanged pcm->cod");
        send(1, 8'hC3);
        recv(0, 1'b1, 8'hC3, "R8 data unchanged cod->pcm");
        law_sel = 1'b0;
        repeat (2) @(posedge pcm_bclk); #1;
        chk(law_status == 1'b0, "R8 law_status low", law_status, 0);

        // R9 duplicate
        recv(1, 1'b1, 8'h3C, "R9 repeated word");
        chk(cod_tx_dup == 1'b1, "R9 cod dup flag", cod_tx_dup, 1);
        chk(pcm_tx_dup == 1'b0, "R9 pcm dup clear", pcm_tx_dup, 0);

        // R10 drop
        send(0, 8'h11);
        send(0, 8'h22);
        recv(1, 1'b1, 8'h22, "R10 newer word sent");
        chk(cod_tx_drop == 1'b1, "R10 cod drop flag", cod_tx_drop, 1);
        chk(pcm_tx_drop == 1'b0, "R10 pcm drop clear", pcm_tx_drop, 0);

        // R6 bypass off: silent and no capture
        bypass = 1'b0;
        repeat (3) @(posedge cod_bclk);
        send(0, 8'h99);
        recv(1, 1'b0, 8'h00, "R6 silent");
        bypass = 1'b1;
        repeat (3) @(posedge cod_bclk);
        recv(1, 1'b1, 8'h22, "R6 word kept");

        // R7 power-down: silent and no capture
        pwr_n = 1'b0;
        repeat (3) @(posedge cod_bclk);
        send(1, 8'h77);
        recv(0, 1'b0, 8'h00, "R7 silent");
        pwr_n = 1'b1;
        repeat (3) @(posedge cod_bclk);
        recv(0, 1'b1, 8'hC3, "R7 word kept");

        // R11 reset word then dup
        do_reset();
        chk({pcm_tx_dup, pcm_tx_drop, cod_tx_dup, cod_tx_drop} == 0, "R11 flags cleared",
            {pcm_tx_dup, pcm_tx_drop, cod_tx_dup, cod_tx_drop}, 0);
        recv(0, 1'b1, 8'hFF, "R11 reset word");
        chk(pcm_tx_dup == 1'b1, "R11 first slot dup", pcm_tx_dup, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule